// File: doc/BRIEF.md
# Row-Activate Rate Limiter

This block decides, for a single rank of DRAM, whether a row activate may be sent on the current cycle. A scheduler presents the bank group of the activate it would like to send on `cand_grp`. The limiter answers with `allowed`. It also returns `earliest`, the first cycle on its own free-running time base (`now_cyc`) at which that activate would be legal. When the scheduler actually sends the command, it raises `issue` in that same cycle. An issue is accepted only while `allowed` is high.

Two rules are enforced together.

- **Sliding window.** A timestamp FIFO holds the accepted activates of the recent past. Once it holds `cfg_limit` entries whose window has not yet run out, a further activate must wait until the oldest entry plus `cfg_xaw`.
- **Activate-to-activate spacing.** Every accepted activate pushes out the earliest legal time of each bank group. A group that differs from the activate's group gets the short gap `cfg_rrd`. The activate's own group gets the long gap `cfg_rrd_l` when grouping is enabled. A later activate never shortens a constraint that is still pending.

`earliest` is the later of the two bounds. All times are taken modulo 2^12, and every comparison is done on the wrapped difference.

Top module: `alw_limiter`

## Requirements
- R1: After reset, `now_cyc` is 0 on the first cycle and then rises by exactly 1 per clock, wrapping at 2^12. With no history, `allowed` is 1 and `earliest` equals `now_cyc`.
- R2: `allowed` is 1 exactly when `earliest` equals `now_cyc`. Otherwise `earliest` lies 1 to 2047 cycles after `now_cyc` in wrapped arithmetic.
- R3: Suppose `cfg_limit` activates have been accepted and the oldest of them was at time t0. Then the next activate is not allowed before t0 + `cfg_xaw`, and it is allowed at that cycle if spacing permits.
- R4: Accepting an activate while the window is full retires the oldest entry. The following window bound becomes the second-oldest time plus `cfg_xaw`.
- R5: After an activate at time t, an activate to a different bank group is not allowed before t + `cfg_rrd`.
- R6: With `cfg_grp_en` = 1, an activate to the same bank group as one accepted at time t is not allowed before t + `cfg_rrd_l`.
- R7: With `cfg_grp_en` = 0, the same-group bound is t + `cfg_rrd`, and `cfg_rrd_l` has no effect.
- R8: `earliest` is the maximum of the window bound and the spacing bound for `cand_grp`. A spacing bound already pending for a group is kept if it is later than a new one.
- R9: An `issue` raised while `allowed` is 0 is ignored. It leaves no timestamp and moves no spacing bound, so `earliest` is unchanged on the next cycle.
- R10: Bounds that straddle the 2^12 wrap of `now_cyc` are reported and enforced exactly as they are away from the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_limit | input | $clog2(DEPTH+1) | Activates allowed per window, from 1 to DEPTH; held stable outside reset |
| cfg_xaw | input | 12 | Window length in cycles, below 2048 |
| cfg_rrd | input | DLY_W | Short activate-to-activate gap |
| cfg_rrd_l | input | DLY_W | Same-group gap, used when grouping is enabled |
| cfg_grp_en | input | 1 | Enables the same-group long gap |
| cand_grp | input | GRP_W | Bank group of the candidate activate |
| issue | input | 1 | The candidate is sent this cycle |
| allowed | output | 1 | The candidate may be sent this cycle |
| earliest | output | 12 | First legal cycle for the candidate, on the `now_cyc` time base |
| now_cyc | output | 12 | Free-running cycle count |

## Verification
The bench targets four kinds of mistake.

- **Off-by-one at the window edge.** The exact cycle where the oldest entry of a full window expires is checked. A design with an off-by-one there would either allow one cycle early or hold `allowed` low one cycle past `earliest`.
- **Wrong bound after the FIFO rolls.** A design that keeps using the first timestamp would report t0 + `cfg_xaw` again after the oldest entry is retired.
- **Same-group versus other-group gaps.** The bench compares the two gaps against each other with grouping both on and off, so a swapped or ignored group compare shows up. It also checks that a refused issue leaves no trace.
- **Counter wrap.** A burst of activates is run across the 2^12 wrap of the time counter. An unsigned compare there would either release activates at once or stall them for a whole counter period.

// File: rtl/alw_pkg.sv
package alw_pkg;

    // Width of the free-running time base; every bound must stay below half its range.
    localparam int unsigned TS_W = 12;

    typedef logic [TS_W-1:0] ts_t;

    // True when a lies strictly after b on the wrapped time line.
    function automatic logic ts_after(input ts_t a, input ts_t b);
        ts_t diff;
        diff = a - b;
        return (diff != '0) && !diff[TS_W-1];
    endfunction

endpackage

// File: rtl/alw_hist.sv
module alw_hist
    import alw_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ts_t              now,
    input  logic [CNT_W-1:0] cfg_limit,
    input  ts_t              cfg_xaw,
    input  logic             push,
    output logic             block,
    output ts_t              target
);

    typedef struct packed {
        logic [DEPTH-1:0][TS_W-1:0] slot;
        logic [PTR_W-1:0]           rd;
        logic [PTR_W-1:0]           wr;
        logic [CNT_W-1:0]           cnt;
    } hist_t;

    hist_t st_d, st_q;
    logic  head_gone;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Window bound seen from the oldest live entry.
    always_comb begin
        target    = st_q.slot[st_q.rd] + cfg_xaw;
        head_gone = (st_q.cnt != '0) && !ts_after(target, now);
        block     = (st_q.cnt != '0) && (st_q.cnt >= cfg_limit) && !head_gone;
    end

    // Expired head retires on its own, one per cycle; accepted activates append.
    always_comb begin
        st_d = st_q;
        if (head_gone) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        if (push) begin
            st_d.slot[st_q.wr] = now;
            st_d.wr            = ptr_inc(st_q.wr);
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(head_gone);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/alw_spacing.sv
module alw_spacing
    import alw_pkg::*;
#(
    parameter int unsigned GRP_W = 2,
    parameter int unsigned DLY_W = 8,
    localparam int unsigned NGRP = 1 << GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ts_t              now,
    input  logic [GRP_W-1:0] grp,
    input  logic             push,
    input  logic [DLY_W-1:0] cfg_rrd,
    input  logic [DLY_W-1:0] cfg_rrd_l,
    input  logic             cfg_grp_en,
    output logic             block,
    output ts_t              target
);

    typedef struct packed {
        logic [NGRP-1:0][TS_W-1:0] tgt;
        logic [NGRP-1:0]           pend;
    } spc_t;

    spc_t st_d, st_q;
    ts_t  gap [NGRP];

    // Per-group gap picked by whether the group matches the activate.
    for (genvar h = 0; h < NGRP; h++) begin : g_gap
        assign gap[h] = (cfg_grp_en && (grp == GRP_W'(h))) ? TS_W'(cfg_rrd_l)
                                                           : TS_W'(cfg_rrd);
    end

    always_comb begin
        target = st_q.tgt[grp];
        block  = st_q.pend[grp] && ts_after(st_q.tgt[grp], now);
    end

    always_comb begin
        ts_t  cand;
        logic live;
        st_d = st_q;
        for (int h = 0; h < NGRP; h++) begin
            live = st_q.pend[h] && ts_after(st_q.tgt[h], now);
            cand = now + gap[h];
            if (push && !(live && ts_after(st_q.tgt[h], cand))) begin
                st_d.tgt[h]  = cand;
                st_d.pend[h] = 1'b1;
            end else begin
                st_d.pend[h] = live;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/alw_limiter.sv
module alw_limiter
    import alw_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned GRP_W = 2,
    parameter int unsigned DLY_W = 8,
    localparam int unsigned LIM_W = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LIM_W-1:0]         cfg_limit,
    input  logic [alw_pkg::TS_W-1:0] cfg_xaw,
    input  logic [DLY_W-1:0]         cfg_rrd,
    input  logic [DLY_W-1:0]         cfg_rrd_l,
    input  logic                     cfg_grp_en,
    input  logic [GRP_W-1:0]         cand_grp,
    input  logic                     issue,
    output logic                     allowed,
    output logic [alw_pkg::TS_W-1:0] earliest,
    output logic [alw_pkg::TS_W-1:0] now_cyc
);

    ts_t  now_d, now_q;
    logic win_block, spc_block, accept;
    ts_t  win_tgt, spc_tgt;

    alw_hist #(.DEPTH(DEPTH)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .now       (now_q),
        .cfg_limit (cfg_limit),
        .cfg_xaw   (cfg_xaw),
        .push      (accept),
        .block     (win_block),
        .target    (win_tgt)
    );

    alw_spacing #(.GRP_W(GRP_W), .DLY_W(DLY_W)) u_spacing (
        .clk        (clk),
        .rst_n      (rst_n),
        .now        (now_q),
        .grp        (cand_grp),
        .push       (accept),
        .cfg_rrd    (cfg_rrd),
        .cfg_rrd_l  (cfg_rrd_l),
        .cfg_grp_en (cfg_grp_en),
        .block      (spc_block),
        .target     (spc_tgt)
    );

    always_comb begin
        allowed = !win_block && !spc_block;
        accept  = issue && allowed;
        if (win_block && spc_block) begin
            earliest = ts_after(win_tgt, spc_tgt) ? win_tgt : spc_tgt;
        end else if (win_block) begin
            earliest = win_tgt;
        end else if (spc_block) begin
            earliest = spc_tgt;
        end else begin
            earliest = now_q;
        end
        now_cyc = now_q;
    end

    always_comb begin
        now_d = now_q + TS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= '0;
        end else begin
            now_q <= now_d;
        end
    end

endmodule

// File: rtl/alw_limiter_chk.sv
module alw_limiter_chk
    import alw_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned GRP_W = 2,
    parameter int unsigned DLY_W = 8,
    localparam int unsigned LIM_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LIM_W-1:0] cfg_limit,
    input ts_t              cfg_xaw,
    input logic [DLY_W-1:0] cfg_rrd,
    input logic [DLY_W-1:0] cfg_rrd_l,
    input logic             cfg_grp_en,
    input logic [GRP_W-1:0] cand_grp,
    input logic             issue,
    input logic             allowed,
    input ts_t              earliest,
    input ts_t              now_cyc
);

    ts_t  gap_q;
    logic seen_q;
    ts_t  min_sp, max_bound, lead;

    always_comb begin
        min_sp = (cfg_grp_en && (cfg_rrd_l < cfg_rrd)) ? TS_W'(cfg_rrd_l) : TS_W'(cfg_rrd);
        max_bound = cfg_xaw;
        if (TS_W'(cfg_rrd) > max_bound) max_bound = TS_W'(cfg_rrd);
        if (cfg_grp_en && (TS_W'(cfg_rrd_l) > max_bound)) max_bound = TS_W'(cfg_rrd_l);
        lead = earliest - now_cyc;
    end

    // Cycles since the last accepted activate, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (issue && allowed) begin
            gap_q  <= TS_W'(1);
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + TS_W'(1);
        end
    end

    assert_time_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (now_cyc == $past(now_cyc) + TS_W'(1)));

    assert_allowed_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
        allowed |-> (earliest == now_cyc));

    assert_blocked_future_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !allowed |-> ts_after(earliest, now_cyc));

    assert_min_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && allowed && seen_q) |-> (gap_q >= min_sp));

    assert_bound_reach_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !allowed |-> (lead <= max_bound));

endmodule

bind alw_limiter alw_limiter_chk #(.DEPTH(DEPTH), .GRP_W(GRP_W), .DLY_W(DLY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_limit  (cfg_limit),
    .cfg_xaw    (cfg_xaw),
    .cfg_rrd    (cfg_rrd),
    .cfg_rrd_l  (cfg_rrd_l),
    .cfg_grp_en (cfg_grp_en),
    .cand_grp   (cand_grp),
    .issue      (issue),
    .allowed    (allowed),
    .earliest   (earliest),
    .now_cyc    (now_cyc)
);

// File: tb/alw_limiter_test.sv
module alw_limiter_test;
    import alw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int GRP_W = 2;
    localparam int DLY_W = 8;
    localparam int NGRP  = 1 << GRP_W;
    localparam int LIM_W = $clog2(DEPTH + 1);
    localparam int TMOD  = 1 << TS_W;

    typedef struct packed {
        logic       wait_ok;
        logic       try_it;
        logic [3:0] gap;
        logic [1:0] grp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 4'd0,  2'd0}, '{1'b0, 1'b1, 4'd0, 2'd0},
        '{1'b1, 1'b1, 4'd0,  2'd1}, '{1'b1, 1'b1, 4'd0, 2'd1},
        '{1'b1, 1'b1, 4'd0,  2'd2}, '{1'b0, 1'b1, 4'd0, 2'd3},
        '{1'b1, 1'b1, 4'd0,  2'd3}, '{1'b1, 1'b1, 4'd2, 2'd0},
        '{1'b0, 1'b1, 4'd0,  2'd1}, '{1'b1, 1'b1, 4'd5, 2'd2},
        '{1'b1, 1'b1, 4'd0,  2'd2}, '{1'b1, 1'b0, 4'd0, 2'd3},
        '{1'b0, 1'b1, 4'd9,  2'd0}, '{1'b1, 1'b1, 4'd0, 2'd1},
        '{1'b1, 1'b1, 4'd0,  2'd3}, '{1'b1, 1'b1, 4'd15, 2'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LIM_W-1:0] cfg_limit = LIM_W'(4);
    logic [TS_W-1:0]  cfg_xaw = TS_W'(40);
    logic [DLY_W-1:0] cfg_rrd = DLY_W'(4);
    logic [DLY_W-1:0] cfg_rrd_l = DLY_W'(6);
    logic             cfg_grp_en = 1'b1;
    logic [GRP_W-1:0] cand_grp = '0;
    logic             issue = 1'b0;
    logic             allowed;
    logic [TS_W-1:0]  earliest;
    logic [TS_W-1:0]  now_cyc;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    int abs_now = 0;
    int n_acc = 0;
    int acc_t [0:1023];
    int grp_e [0:NGRP-1];

    alw_limiter #(.DEPTH(DEPTH), .GRP_W(GRP_W), .DLY_W(DLY_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_limit  (cfg_limit),
        .cfg_xaw    (cfg_xaw),
        .cfg_rrd    (cfg_rrd),
        .cfg_rrd_l  (cfg_rrd_l),
        .cfg_grp_en (cfg_grp_en),
        .cand_grp   (cand_grp),
        .issue      (issue),
        .allowed    (allowed),
        .earliest   (earliest),
        .now_cyc    (now_cyc)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model on absolute (unwrapped) time.
    function automatic int model_earliest(input int g);
        int e;
        e = abs_now;
        if (n_acc >= int'(cfg_limit) && acc_t[n_acc - int'(cfg_limit)] + int'(cfg_xaw) > e)
            e = acc_t[n_acc - int'(cfg_limit)] + int'(cfg_xaw);
        if (grp_e[g] > e) e = grp_e[g];
        return e;
    endfunction

    task automatic model_accept(input int g);
        int d;
        acc_t[n_acc] = abs_now;
        n_acc++;
        for (int h = 0; h < NGRP; h++) begin
            d = (cfg_grp_en && h == g) ? int'(cfg_rrd_l) : int'(cfg_rrd);
            if (abs_now + d > grp_e[h]) grp_e[h] = abs_now + d;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        abs_now++;
        @(negedge clk);
        issue = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        issue = 1'b0;
        repeat (3) @(negedge clk);
        n_acc = 0;
        for (int h = 0; h < NGRP; h++) grp_e[h] = 0;
        rst_n = 1'b1;
        abs_now = 0;
    endtask

    task automatic peek(input int g);
        cand_grp = GRP_W'(g);
        #1;
    endtask

    // One cycle: compare against the model, optionally try to issue, advance.
    task automatic do_step(input int g, input bit try_it, input string tag);
        int exp_e;
        bit exp_ok;
        peek(g);
        exp_e  = model_earliest(g);
        exp_ok = (exp_e == abs_now);
        chk(int'(now_cyc) == abs_now % TMOD, {tag, " R1 now"}, int'(now_cyc), abs_now % TMOD);
        chk(allowed == exp_ok, {tag, " allowed"}, int'(allowed), int'(exp_ok));
        chk(int'(earliest) == exp_e % TMOD, {tag, " earliest"}, int'(earliest), exp_e % TMOD);
        if (try_it) begin
            issue = 1'b1;
            if (exp_ok) model_accept(g);
        end
        tick();
    endtask

    task automatic wait_ok(input int g);
        while (model_earliest(g) != abs_now) tick();
    endtask

    task automatic run_table(input string tag);
        for (int i = 0; i < NV; i++) begin
            repeat (int'(VECS[i].gap)) tick();
            if (VECS[i].wait_ok) wait_ok(int'(VECS[i].grp));
            do_step(int'(VECS[i].grp), VECS[i].try_it, tag);
        end
    endtask

    initial begin
        do_reset();

        // R1: reset state
        peek(0);
        chk(now_cyc == '0, "R1 now after reset", int'(now_cyc), 0);
        chk(allowed == 1'b1, "R1 allowed after reset", int'(allowed), 1);
        chk(earliest == '0, "R1 earliest after reset", int'(earliest), 0);
        do_step(0, 1'b1, "R1");

        // R6 / R5: same-group and other-group gaps after the activate at 0
        peek(0);
        chk(int'(earliest) == 6 && !allowed, "R6 same group gap", int'(earliest), 6);
        peek(1);
        chk(int'(earliest) == 4 && !allowed, "R5 other group gap", int'(earliest), 4);

        wait_ok(1); do_step(1, 1'b1, "R5");
        wait_ok(2); do_step(2, 1'b1, "R5");
        wait_ok(3); do_step(3, 1'b1, "R5");

        // R3: window full with activates at 0,4,8,12
        peek(0);
        chk(int'(earliest) == 40, "R3 window bound", int'(earliest), 40);
        do_step(0, 1'b1, "R9");
        peek(0);
        chk(int'(earliest) == 40 && !allowed, "R9 refused issue left no trace", int'(earliest), 40);
        wait_ok(0);
        peek(0);
        chk(abs_now == 40 && allowed, "R3 allowed at window edge", abs_now, 40);
        do_step(0, 1'b1, "R3");

        // R8 / R4: after the roll, window from entry at 4
        peek(0);
        chk(int'(earliest) == 46, "R8 spacing dominates window", int'(earliest), 46);
        peek(1);
        chk(int'(earliest) == 44, "R4 window from second entry", int'(earliest), 44);

        run_table("R2/R8 table");

        // R10: run the table across the counter wrap
        while (abs_now < TMOD - 30) tick();
        run_table("R10 wrap table");
        chk(abs_now > TMOD, "R10 crossed wrap", abs_now, TMOD);

        // R7: grouping disabled
        cfg_grp_en = 1'b0;
        do_reset();
        do_step(2, 1'b1, "R7");
        peek(2);
        chk(int'(earliest) == 4, "R7 same group uses short gap", int'(earliest), 4);
        peek(1);
        chk(int'(earliest) == 4, "R7 other group gap", int'(earliest), 4);
        run_table("R7 table");

        summary();
    end

endmodule